// File: doc/BRIEF.md
# Issue Structural-Hazard Reservation Tracker

This block sits beside the issue stage of a multi-unit in-order core. It keeps a look-ahead calendar of when each execution resource is booked and decides, in the same cycle, which of up to three decoded instructions can issue. Each instruction class books its own multi-cycle pattern. That pattern covers the decode slots, the two simple integer units, the two-stage complex integer pipe, the non-pipelined divider, the load/store unit, the FPU, the branch unit, the vector unit and the permute unit.

Requests are presented with a valid bit and a 5-bit class code. The tracker answers combinationally with a grant per slot and the result latency of each granted instruction. On each clock edge it commits the bookings of all granted requests and advances the calendar by one cycle. Data dependences, renaming and flushes belong to other logic.

Top module: `issue_rsv_tracker`

## Requirements
- R1: Slots are judged in order 0, 1, 2, and each slot sees the bookings of earlier grants in the same cycle. A slot that is not granted shows latency 0. Every non-branch class books one of two decode slots in its issue cycle, with slot 0 taken first, so at most two non-branch requests are granted per cycle.
- R2: The branch class (code 19, latency 1) needs no decode slot and books the branch unit for one cycle. A third instruction can therefore issue beside two others, but never more than one branch per cycle.
- R3: Plain simple integer ops (code 1) have latency 1. Compare/trap/record-form ops (code 2) have latency 2. Each books one simple unit for one cycle, unit 0 first and unit 1 if unit 0 is busy.
- R4: A variable-amount shift (code 3, latency 2) books the same simple unit for two consecutive cycles.
- R5: Move-from-condition-register (code 6, latency 4) books simple unit 0 for four cycles. Move-to-condition-register (code 7, latency 1) needs unit 0 for one cycle. Neither may fall back to unit 1.
- R6: The two-part class (code 4, latency 2) books decode in its issue cycle and the next one, and one simple unit in the two cycles after issue. The three-part class (code 5, latency 3) books decode for three cycles and one simple unit for the three cycles after issue.
- R7: A plain multiply (code 8, latency 4) books complex stage 0 and then stage 1. A long multiply (code 9, latency 5) books stage 0, then both stages, then stage 1.
- R8: A divide books complex stage 0 and the divider in its first execute cycle, then the divider alone. The 32-bit divide (code 10, latency 16) holds the divider for 16 cycles in total, and the 64-bit divide (code 11, latency 26) for 26.
- R9: Other FP ops (code 16, latency 7) book the FPU for one cycle. Single divide (code 17, latency 20) holds it for 20 cycles and double divide (code 18, latency 35) for 35.
- R10: Load (12) and store (14) have latency 3. Wide load (13) and vector store (15) have latency 4, and all four book the load/store unit for one cycle. Vector simple (20), complex (21) and float (22) book the vector unit for one cycle with latencies 1, 4 and 6. Permute (23) books its own unit with latency 2.
- R11: A request with the valid bit low, or with a class code outside 1..23, is never granted and books nothing.
- R12: A request is granted only if its whole pattern fits. A refused request leaves no partial booking.
- R13: Reset clears every booking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NSLOT | Request valid per slot |
| req_cls_i | input | NSLOT x 5 | Class code per slot |
| grant_o | output | NSLOT | Grant per slot, same cycle |
| lat_o | output | NSLOT x LAT_W | Result latency per granted slot, 0 otherwise |

## Verification
The assertions assume that class codes and valid bits are settled before the clock edge and stay steady across it, since grants are a combinational function of them. They also assume that a refused request may simply be presented again in a later cycle. The stimulus changes inputs only just after the falling edge and samples results one nanosecond later. Each scenario starts from a fresh reset, so every expected grant follows from the bookings made inside that scenario alone.

// File: rtl/issue_rsv_pkg.sv
package issue_rsv_pkg;
  localparam int CLS_W = 5;
  localparam int NRES  = 12;

  localparam int RS_DEC0  = 0;
  localparam int RS_DEC1  = 1;
  localparam int RS_SFX0  = 2;
  localparam int RS_SFX1  = 3;
  localparam int RS_CFX0  = 4;
  localparam int RS_CFX1  = 5;
  localparam int RS_DIV   = 6;
  localparam int RS_LSU   = 7;
  localparam int RS_FPU   = 8;
  localparam int RS_BU    = 9;
  localparam int RS_VEC   = 10;
  localparam int RS_VPERM = 11;

  localparam logic [CLS_W-1:0] CL_SFX     = 5'd1;
  localparam logic [CLS_W-1:0] CL_SFX_REC = 5'd2;
  localparam logic [CLS_W-1:0] CL_SHVAR   = 5'd3;
  localparam logic [CLS_W-1:0] CL_TWO     = 5'd4;
  localparam logic [CLS_W-1:0] CL_THREE   = 5'd5;
  localparam logic [CLS_W-1:0] CL_MFCR    = 5'd6;
  localparam logic [CLS_W-1:0] CL_MTCR    = 5'd7;
  localparam logic [CLS_W-1:0] CL_MUL     = 5'd8;
  localparam logic [CLS_W-1:0] CL_MUL_LNG = 5'd9;
  localparam logic [CLS_W-1:0] CL_DIV32   = 5'd10;
  localparam logic [CLS_W-1:0] CL_DIV64   = 5'd11;
  localparam logic [CLS_W-1:0] CL_LOAD    = 5'd12;
  localparam logic [CLS_W-1:0] CL_LOAD_W  = 5'd13;
  localparam logic [CLS_W-1:0] CL_STORE   = 5'd14;
  localparam logic [CLS_W-1:0] CL_VSTORE  = 5'd15;
  localparam logic [CLS_W-1:0] CL_FP      = 5'd16;
  localparam logic [CLS_W-1:0] CL_FDIVS   = 5'd17;
  localparam logic [CLS_W-1:0] CL_FDIVD   = 5'd18;
  localparam logic [CLS_W-1:0] CL_BR      = 5'd19;
  localparam logic [CLS_W-1:0] CL_VSIMP   = 5'd20;
  localparam logic [CLS_W-1:0] CL_VCPLX   = 5'd21;
  localparam logic [CLS_W-1:0] CL_VFLT    = 5'd22;
  localparam logic [CLS_W-1:0] CL_VPERM   = 5'd23;
endpackage

// File: rtl/rsv_cls_decode.sv
module rsv_cls_decode
  import issue_rsv_pkg::*;
#(
  parameter int HORIZON = 40,
  parameter int LAT_W   = 6
) (
  input  logic [CLS_W-1:0]              cls_i,
  output logic                          known_o,
  output logic                          pin0_o,
  output logic [NRES-1:0][HORIZON-1:0]  pat_o,
  output logic [LAT_W-1:0]              lat_o
);
  function automatic logic [HORIZON-1:0] span(input int s, input int n);
    logic [HORIZON-1:0] m;
    for (int k = 0; k < HORIZON; k++) m[k] = (k >= s) && (k < s + n);
    return m;
  endfunction

  // Pattern bit k = resource busy k cycles after the issue cycle.
  // DEC0/SFX0 columns mean "either instance"; the allocator picks one.
  always_comb begin
    pat_o          = '0;
    known_o        = 1'b1;
    pin0_o         = 1'b0;
    lat_o          = '0;
    pat_o[RS_DEC0] = span(0, 1);
    case (cls_i)
      CL_SFX:     begin pat_o[RS_SFX0] = span(1, 1); lat_o = LAT_W'(1); end
      CL_SFX_REC: begin pat_o[RS_SFX0] = span(1, 1); lat_o = LAT_W'(2); end
      CL_SHVAR:   begin pat_o[RS_SFX0] = span(1, 2); lat_o = LAT_W'(2); end
      CL_TWO: begin
        pat_o[RS_DEC0] = span(0, 2);
        pat_o[RS_SFX0] = span(1, 2);
        lat_o          = LAT_W'(2);
      end
      CL_THREE: begin
        pat_o[RS_DEC0] = span(0, 3);
        pat_o[RS_SFX0] = span(1, 3);
        lat_o          = LAT_W'(3);
      end
      CL_MFCR: begin pat_o[RS_SFX0] = span(1, 4); pin0_o = 1'b1; lat_o = LAT_W'(4); end
      CL_MTCR: begin pat_o[RS_SFX0] = span(1, 1); pin0_o = 1'b1; lat_o = LAT_W'(1); end
      CL_MUL: begin
        pat_o[RS_CFX0] = span(1, 1);
        pat_o[RS_CFX1] = span(2, 1);
        lat_o          = LAT_W'(4);
      end
      CL_MUL_LNG: begin
        pat_o[RS_CFX0] = span(1, 2);
        pat_o[RS_CFX1] = span(2, 2);
        lat_o          = LAT_W'(5);
      end
      CL_DIV32: begin
        pat_o[RS_CFX0] = span(1, 1);
        pat_o[RS_DIV]  = span(1, 16);
        lat_o          = LAT_W'(16);
      end
      CL_DIV64: begin
        pat_o[RS_CFX0] = span(1, 1);
        pat_o[RS_DIV]  = span(1, 26);
        lat_o          = LAT_W'(26);
      end
      CL_LOAD:   begin pat_o[RS_LSU] = span(1, 1); lat_o = LAT_W'(3); end
      CL_LOAD_W: begin pat_o[RS_LSU] = span(1, 1); lat_o = LAT_W'(4); end
      CL_STORE:  begin pat_o[RS_LSU] = span(1, 1); lat_o = LAT_W'(3); end
      CL_VSTORE: begin pat_o[RS_LSU] = span(1, 1); lat_o = LAT_W'(4); end
      CL_FP:     begin pat_o[RS_FPU] = span(1, 1);  lat_o = LAT_W'(7);  end
      CL_FDIVS:  begin pat_o[RS_FPU] = span(1, 20); lat_o = LAT_W'(20); end
      CL_FDIVD:  begin pat_o[RS_FPU] = span(1, 35); lat_o = LAT_W'(35); end
      CL_BR: begin
        pat_o[RS_DEC0] = '0;
        pat_o[RS_BU]   = span(1, 1);
        lat_o          = LAT_W'(1);
      end
      CL_VSIMP:  begin pat_o[RS_VEC]   = span(1, 1); lat_o = LAT_W'(1); end
      CL_VCPLX:  begin pat_o[RS_VEC]   = span(1, 1); lat_o = LAT_W'(4); end
      CL_VFLT:   begin pat_o[RS_VEC]   = span(1, 1); lat_o = LAT_W'(6); end
      CL_VPERM:  begin pat_o[RS_VPERM] = span(1, 1); lat_o = LAT_W'(2); end
      default: begin
        known_o        = 1'b0;
        pat_o[RS_DEC0] = '0;
      end
    endcase
  end
endmodule

// File: rtl/rsv_slot_alloc.sv
module rsv_slot_alloc
  import issue_rsv_pkg::*;
#(
  parameter int HORIZON = 40
) (
  input  logic                          valid_i,
  input  logic                          known_i,
  input  logic                          pin0_i,
  input  logic [NRES-1:0][HORIZON-1:0]  pat_i,
  input  logic [NRES-1:0][HORIZON-1:0]  tbl_i,
  output logic                          grant_o,
  output logic [NRES-1:0][HORIZON-1:0]  tbl_o
);
  logic [HORIZON-1:0]            d_use0, d_use1, s_use0, s_use1;
  logic                          s_fit0, s_fit1, fit;
  logic [NRES-1:0][HORIZON-1:0]  placed;

  always_comb begin
    fit = 1'b1;
    for (int r = 0; r < NRES; r++) begin
      placed[r] = pat_i[r];
      if (r != RS_DEC0 && r != RS_SFX0) fit = fit & ~|(pat_i[r] & tbl_i[r]);
    end
    // decode: per cycle, slot 0 if free else slot 1
    d_use0 = pat_i[RS_DEC0] & ~tbl_i[RS_DEC0];
    d_use1 = pat_i[RS_DEC0] &  tbl_i[RS_DEC0];
    fit    = fit & ~|(d_use1 & tbl_i[RS_DEC1]);
    // simple unit: one instance for the whole pattern, unit 0 first
    s_fit0 = ~|(pat_i[RS_SFX0] & tbl_i[RS_SFX0]);
    s_fit1 = !pin0_i && ~|(pat_i[RS_SFX0] & tbl_i[RS_SFX1]);
    s_use0 = s_fit0 ? pat_i[RS_SFX0] : '0;
    s_use1 = (!s_fit0 && s_fit1) ? pat_i[RS_SFX0] : '0;
    fit    = fit & (s_fit0 | s_fit1);
    placed[RS_DEC0] = d_use0;
    placed[RS_DEC1] = pat_i[RS_DEC1] | d_use1;
    placed[RS_SFX0] = s_use0;
    placed[RS_SFX1] = pat_i[RS_SFX1] | s_use1;
    grant_o = valid_i & known_i & fit;
    for (int r = 0; r < NRES; r++) tbl_o[r] = grant_o ? (tbl_i[r] | placed[r]) : tbl_i[r];
  end
endmodule

// File: rtl/issue_rsv_tracker.sv
module issue_rsv_tracker
  import issue_rsv_pkg::*;
#(
  parameter int NSLOT   = 3,
  parameter int HORIZON = 40,
  parameter int LAT_W   = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NSLOT-1:0]            req_valid_i,
  input  logic [NSLOT-1:0][CLS_W-1:0] req_cls_i,
  output logic [NSLOT-1:0]            grant_o,
  output logic [NSLOT-1:0][LAT_W-1:0] lat_o
);
  logic [NRES-1:0][HORIZON-1:0] tbl_q;
  logic [NRES-1:0][HORIZON-1:0] tbl_c [NSLOT+1];

  assign tbl_c[0] = tbl_q;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic                         known, pin0;
    logic [NRES-1:0][HORIZON-1:0] pat;
    logic [LAT_W-1:0]             lat;

    rsv_cls_decode #(.HORIZON(HORIZON), .LAT_W(LAT_W)) u_dec (
      .cls_i   (req_cls_i[g]),
      .known_o (known),
      .pin0_o  (pin0),
      .pat_o   (pat),
      .lat_o   (lat)
    );

    rsv_slot_alloc #(.HORIZON(HORIZON)) u_alloc (
      .valid_i (req_valid_i[g]),
      .known_i (known),
      .pin0_i  (pin0),
      .pat_i   (pat),
      .tbl_i   (tbl_c[g]),
      .grant_o (grant_o[g]),
      .tbl_o   (tbl_c[g+1])
    );

    assign lat_o[g] = grant_o[g] ? lat : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else begin
      for (int r = 0; r < NRES; r++) tbl_q[r] <= {1'b0, tbl_c[NSLOT][r][HORIZON-1:1]};
    end
  end
endmodule

// File: rtl/issue_rsv_chk.sv
module issue_rsv_chk
  import issue_rsv_pkg::*;
#(
  parameter int NSLOT = 3,
  parameter int LAT_W = 6
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NSLOT-1:0]            req_valid_i,
  input logic [NSLOT-1:0][CLS_W-1:0] req_cls_i,
  input logic [NSLOT-1:0]            grant_o,
  input logic [NSLOT-1:0][LAT_W-1:0] lat_o
);
  logic [NSLOT-1:0] br_m, unk_m, mfcr_m, pin_m, div_m, fp_m;

  always_comb begin
    for (int i = 0; i < NSLOT; i++) begin
      br_m[i]   = req_cls_i[i] == CL_BR;
      unk_m[i]  = (req_cls_i[i] == '0) || (req_cls_i[i] > CL_VPERM);
      mfcr_m[i] = req_cls_i[i] == CL_MFCR;
      pin_m[i]  = (req_cls_i[i] == CL_MFCR) || (req_cls_i[i] == CL_MTCR);
      div_m[i]  = (req_cls_i[i] == CL_DIV32) || (req_cls_i[i] == CL_DIV64);
      fp_m[i]   = req_cls_i[i] == CL_FP;
    end
  end

  // R11
  no_bad_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(grant_o & (unk_m | ~req_valid_i))));

  // R2
  one_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o & br_m) <= 1);

  // R1
  dec_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_o & ~br_m) <= 2);

  // R5
  sfx0_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(grant_o & mfcr_m) |=> !(|(grant_o & pin_m)));

  // R8
  div_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(grant_o & div_m) |=> !(|(grant_o & div_m)));

  for (genvar g = 0; g < NSLOT; g++) begin : g_lat
    // R9
    fp_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[g] && fp_m[g]) |-> (lat_o[g] == LAT_W'(7)));
    // R1
    lat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !grant_o[g] |-> (lat_o[g] == '0));
  end
endmodule

bind issue_rsv_tracker issue_rsv_chk #(.NSLOT(NSLOT), .LAT_W(LAT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_cls_i   (req_cls_i),
  .grant_o     (grant_o),
  .lat_o       (lat_o)
);

// File: tb/issue_rsv_tracker_tb.sv
module issue_rsv_tracker_tb;
  localparam int SFX = 1, SREC = 2, SHV = 3, TWO = 4, THR = 5, MFCR = 6, MTCR = 7;
  localparam int MUL = 8, MULL = 9, DV32 = 10, DV64 = 11, LD = 12, LDW = 13, ST = 14;
  localparam int VST = 15, FP = 16, FDS = 17, FDD = 18, BR = 19;
  localparam int VS = 20, VC = 21, VF = 22, VP = 23;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       req_valid_i = '0;
  logic [2:0][4:0]  req_cls_i = '0;
  logic [2:0]       grant_o;
  logic [2:0][5:0]  lat_o;
  int               n_tests = 0;
  int               n_fail = 0;
  bit               done = 0;

  always #2 clk_i = ~clk_i;

  issue_rsv_tracker u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_cls_i   (req_cls_i),
    .grant_o     (grant_o),
    .lat_o       (lat_o)
  );

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_valid_i = '0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic drive(input int c0, input int c1, input int c2, input logic [2:0] v);
    @(negedge clk_i);
    req_cls_i[0] = 5'(c0);
    req_cls_i[1] = 5'(c1);
    req_cls_i[2] = 5'(c2);
    req_valid_i  = v;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 3'b000);
  endtask

  task automatic chk(input int s, input bit eg, input int el, input string tag);
    n_tests++;
    if (grant_o[s] !== eg || lat_o[s] !== 6'(el)) begin
      n_fail++;
      $display("FAIL %s slot%0d: grant=%b lat=%0d expected grant=%b lat=%0d",
               tag, s, grant_o[s], lat_o[s], eg, el);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    drive(SFX, SFX, SFX, 3'b000);
    chk(0, 0, 0, "R11 reset idle");
    chk(1, 0, 0, "R11 reset idle");
    chk(2, 0, 0, "R11 reset idle");
    drive(SFX, 0, 0, 3'b001);
    chk(0, 1, 1, "R3 sfx");
  endtask

  task automatic t_decode_cap();
    do_reset();
    drive(SFX, SREC, LD, 3'b111);
    chk(0, 1, 1, "R3 sfx unit0");
    chk(1, 1, 2, "R3 rec unit1");
    chk(2, 0, 0, "R1 decode full");
    drive(SFX, SFX, BR, 3'b111);
    chk(0, 1, 1, "R1 slot0");
    chk(1, 1, 1, "R1 slot1");
    chk(2, 1, 1, "R2 branch third");
    drive(SFX, SFX, SFX, 3'b111);
    chk(2, 0, 0, "R3 both sfx busy");
  endtask

  task automatic t_branch();
    do_reset();
    drive(BR, BR, SFX, 3'b111);
    chk(0, 1, 1, "R2 br");
    chk(1, 0, 0, "R2 second br");
    chk(2, 1, 1, "R2 sfx beside br");
  endtask

  task automatic t_shvar();
    do_reset();
    drive(SHV, 0, 0, 3'b001);
    chk(0, 1, 2, "R4 shvar");
    drive(SFX, SFX, 0, 3'b011);
    chk(0, 1, 1, "R4 unit1 free");
    chk(1, 0, 0, "R4 unit0 still held");
  endtask

  task automatic t_mfcr();
    do_reset();
    drive(MFCR, 0, 0, 3'b001);
    chk(0, 1, 4, "R5 mfcr");
    drive(MTCR, SFX, 0, 3'b011);
    chk(0, 0, 0, "R5 mtcr pinned");
    chk(1, 1, 1, "R5 sfx on unit1");
    idle(1);
    drive(MTCR, 0, 0, 3'b001);
    chk(0, 0, 0, "R5 mtcr at +3");
    drive(MTCR, 0, 0, 3'b001);
    chk(0, 1, 1, "R5 mtcr at +4");
  endtask

  task automatic t_multi_decode();
    do_reset();
    drive(TWO, SFX, LD, 3'b111);
    chk(0, 1, 2, "R6 two");
    chk(1, 1, 1, "R6 sfx beside two");
    chk(2, 0, 0, "R6 decode full");
    drive(LD, FP, 0, 3'b011);
    chk(0, 1, 3, "R6 load dec1");
    chk(1, 0, 0, "R6 two holds dec");
    do_reset();
    drive(THR, 0, 0, 3'b001);
    chk(0, 1, 3, "R6 three");
    for (int i = 0; i < 2; i++) begin
      drive(LD, FP, 0, 3'b011);
      chk(0, 1, 3, "R6 load");
      chk(1, 0, 0, "R6 three holds dec");
    end
    drive(LD, FP, 0, 3'b011);
    chk(1, 1, 7, "R6 decode freed");
  endtask

  task automatic t_mul();
    do_reset();
    drive(MULL, MUL, 0, 3'b011);
    chk(0, 1, 5, "R7 long mul");
    chk(1, 0, 0, "R7 stage0 busy");
    drive(MUL, 0, 0, 3'b001);
    chk(0, 0, 0, "R7 stage0 busy +1");
    drive(MUL, 0, 0, 3'b001);
    chk(0, 1, 4, "R7 mul +2");
  endtask

  task automatic t_div();
    do_reset();
    drive(DV32, DV64, 0, 3'b011);
    chk(0, 1, 16, "R8 div32");
    chk(1, 0, 0, "R8 divider busy");
    drive(MUL, DV32, 0, 3'b011);
    chk(0, 1, 4, "R8 mul beside div");
    chk(1, 0, 0, "R8 divider busy +1");
    idle(13);
    drive(DV32, 0, 0, 3'b001);
    chk(0, 0, 0, "R8 divider busy +15");
    drive(DV64, 0, 0, 3'b001);
    chk(0, 1, 26, "R8 div64 +16");
  endtask

  task automatic t_fp();
    do_reset();
    drive(FDD, FDS, 0, 3'b011);
    chk(0, 1, 35, "R9 fdivd");
    chk(1, 0, 0, "R9 fpu busy");
    idle(33);
    drive(FP, 0, 0, 3'b001);
    chk(0, 0, 0, "R9 fpu busy +34");
    drive(FP, 0, 0, 3'b001);
    chk(0, 1, 7, "R9 fp +35");
    do_reset();
    drive(FDS, 0, 0, 3'b001);
    chk(0, 1, 20, "R9 fdivs");
    idle(18);
    drive(FP, 0, 0, 3'b001);
    chk(0, 0, 0, "R9 fpu busy +19");
    drive(FP, 0, 0, 3'b001);
    chk(0, 1, 7, "R9 fp +20");
  endtask

  task automatic t_lsu_vec();
    do_reset();
    drive(VS, VP, LD, 3'b111);
    chk(0, 1, 1, "R10 vsimple");
    chk(1, 1, 2, "R10 vperm");
    chk(2, 0, 0, "R10 decode full");
    drive(VC, VF, 0, 3'b011);
    chk(0, 1, 4, "R10 vcomplex");
    chk(1, 0, 0, "R10 vec busy");
    drive(VF, LDW, 0, 3'b011);
    chk(0, 1, 6, "R10 vfloat");
    chk(1, 1, 4, "R10 wide load");
    drive(ST, VST, 0, 3'b011);
    chk(0, 1, 3, "R10 store");
    chk(1, 0, 0, "R10 lsu busy");
    drive(VST, LD, 0, 3'b011);
    chk(0, 1, 4, "R10 vstore");
    chk(1, 0, 0, "R10 lsu busy 2");
    drive(LD, 0, 0, 3'b001);
    chk(0, 1, 3, "R10 load");
  endtask

  task automatic t_unknown();
    do_reset();
    drive(0, 31, SFX, 3'b111);
    chk(0, 0, 0, "R11 code0");
    chk(1, 0, 0, "R11 code31");
    chk(2, 1, 1, "R11 nothing booked");
    drive(SFX, SFX, SFX, 3'b110);
    chk(0, 0, 0, "R11 invalid");
    chk(1, 1, 1, "R11 invalid books nothing");
    chk(2, 1, 1, "R11 invalid books nothing");
  endtask

  task automatic t_atomic();
    do_reset();
    drive(MFCR, SHV, 0, 3'b011);
    chk(0, 1, 4, "R12 mfcr");
    chk(1, 1, 2, "R12 shvar unit1");
    drive(THR, LD, FP, 3'b111);
    chk(0, 0, 0, "R12 three refused");
    chk(1, 1, 3, "R12 no partial dec0");
    chk(2, 1, 7, "R12 no partial dec1");
    drive(LD, FP, 0, 3'b011);
    chk(0, 1, 3, "R12 next cycle dec0");
    chk(1, 1, 7, "R12 next cycle dec1");
  endtask

  task automatic t_reset_clear();
    do_reset();
    drive(FDD, MFCR, DV64, 3'b111);
    chk(0, 1, 35, "R13 fill");
    do_reset();
    drive(FP, MTCR, DV32, 3'b111);
    chk(0, 1, 7, "R13 fpu cleared");
    chk(1, 1, 1, "R13 sfx0 cleared");
    chk(2, 0, 0, "R13 decode full");
    drive(DV32, 0, 0, 3'b001);
    chk(0, 1, 16, "R13 divider cleared");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_decode_cap();
    t_branch();
    t_shvar();
    t_mfcr();
    t_multi_decode();
    t_mul();
    t_div();
    t_fp();
    t_lsu_vec();
    t_unknown();
    t_atomic();
    t_reset_clear();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule